// File: doc/BRIEF.md
# Buffered SPI Master Engine

This block is a single-channel serial master that moves one word at a time between a one-word transmit holding register and a one-word receive holding register. A control word sets the word length (8 or 16 bits), the shift order, the idle level of the serial clock, the clock phase and a clock divider. The same control word also selects two buffer policies. The first decides what is sent when a transfer starts with the transmit holding register empty. The second decides what happens to a word that arrives while the receive holding register still holds an unread word.

A transfer starts when the engine is enabled and idle and the transmit holding register is full. It also starts when software reads the receive holding register while the transmit holding register is empty, which gives a read-driven mode. A status vector reports three live buffer and activity bits and four sticky event bits. Software clears the sticky bits by writing ones to a clear mask.

An optional select-sense input detects a second master driving the bus. When that happens the engine halts and stays halted until software clears the fault.

Top module: `spi_bufmaster`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `status` is all zeros and the control word is zero, so the engine is disabled.
- R2: Control bit 1 selects the word length. A value of 0 gives 8-bit words, received into `rx_rdata[7:0]` with the upper byte zero. A value of 1 gives 16-bit words.
- R3: Control bit 2 selects the shift order. A value of 0 shifts the most significant bit first on both `mosi` and `miso`. A value of 1 shifts the least significant bit first.
- R4: Control bit 3 is the clock polarity. `sclk` rests at this level whenever no transfer is running.
- R5: Control bit 4 is the clock phase. With 0, the first bit is on `mosi` when `ss_n` falls, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. With 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: Control bits 15:8 hold a divider D, which must be at least 1. Each half period of `sclk` lasts D+1 clock cycles, so `ss_n` stays low for 2·N·(D+1) cycles for an N-bit word.
- R7: When the engine is enabled (control bit 0) and idle, a full transmit holding register starts a transfer. A word written during a transfer is queued and starts the next transfer. A pulse on `rx_re` while idle with the transmit holding register empty also starts a transfer.
- R8: A transfer that starts with the transmit holding register empty sends zeros if control bit 5 is 0. If control bit 5 is 1, it resends the word most recently taken from the holding register. In both cases it sets sticky `status[1]`.
- R9: A word that completes while the receive holding register is full (and not being read in that cycle) sets sticky `status[2]`. If control bit 6 is 1, the new word replaces the held word. If control bit 6 is 0, the new word is dropped.
- R10: Sticky `status[0]` is set when a word completes. `status[4]` shows the transmit holding register full, `status[5]` shows the receive holding register full, and `status[6]` shows a transfer in progress.
- R11: A pulse on `clr_we` clears each sticky bit `status[3:0]` whose bit in `clr_mask` is 1. A set event in the same cycle wins over the clear.
- R12: With control bit 7 and control bit 0 set, a low level on `ss_in_n` (after a two-stage synchronizer) sets sticky `status[3]`. While that bit is set, any running transfer stops, `ss_n` goes high, `sclk` goes idle and no transfer starts.
- R13: Clearing control bit 0 stops a running transfer on the next cycle. `ss_n` returns high and `sclk` returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| tx_we | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 16 | Word to transmit |
| rx_re | input | 1 | Receive holding register read strobe |
| rx_rdata | output | 16 | Receive holding register contents |
| clr_we | input | 1 | Sticky flag clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask for status[3:0] |
| status | output | 7 | {busy, rx full, tx full, mode fault, rx overflow, tx underflow, word done} |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| ss_in_n | input | 1 | Select-sense input for mode-fault detection |

## Verification
The engine is exercised in a 16-bit, MSB-first, phase-0 setup and in an 8-bit, LSB-first, inverted-polarity, phase-1 setup with a wider divider. Comparing the two separates errors in bit indexing, sample-edge choice and half-period length. Back-to-back queued writes show that a word written mid-transfer starts the next one without loss. Read-driven starts with the holding register empty, run once under each underflow policy, tell zero fill apart from resending the last word. Two completions without a read, under each overflow policy, separate drop from replace. A select-sense assertion during a transfer and a disable during a transfer check that both abort paths stop the bus at once and hold it stopped.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    localparam int DATA_W    = 16;
    localparam int NARROW_W  = 8;
    localparam int DIV_W     = 8;
    localparam int STICKY_W  = 4;
    localparam int EDGE_W    = $clog2(2 * DATA_W + 1);
    localparam int POS_W     = $clog2(DATA_W);

    // Control word, bit 0 at the bottom.
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ssin_en;
        logic             get_more;
        logic             send_last;
        logic             cpha;
        logic             cpol;
        logic             lsb_first;
        logic             wide;
        logic             enable;
    } ctl_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic tx_full;
        logic fault;
        logic rx_over;
        logic tx_under;
        logic done;
    } stat_t;

    localparam int CTL_W  = $bits(ctl_t);
    localparam int STAT_W = $bits(stat_t);

    // Position in the data word of the b-th bit on the wire.
    function automatic logic [POS_W-1:0] bit_pos(input logic [POS_W-1:0] b,
                                                 input logic wide,
                                                 input logic lsb);
        logic [POS_W-1:0] top;
        top = wide ? POS_W'(DATA_W - 1) : POS_W'(NARROW_W - 1);
        return lsb ? b : (top - b);
    endfunction

    function automatic logic [EDGE_W-1:0] edges_for(input logic wide);
        return wide ? EDGE_W'(2 * DATA_W) : EDGE_W'(2 * NARROW_W);
    endfunction

endpackage

// File: rtl/spi_bm_sync.sv
module spi_bm_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_bm_halftick.sv
module spi_bm_halftick
    import spi_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic              lsb,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    logic [EDGE_W-1:0] edge_q;
    logic [DATA_W-1:0] txw_q, rxw_q;
    logic [POS_W-1:0]  drv_bit, smp_bit;
    logic              is_sample;

    always_comb begin
        smp_bit = POS_W'(edge_q >> 1);
        if (cpha && (edge_q != '0)) drv_bit = POS_W'((edge_q - EDGE_W'(1)) >> 1);
        else                        drv_bit = POS_W'(edge_q >> 1);
        is_sample = (edge_q[0] == cpha);
    end

    assign sclk    = busy ? (cpol ^ edge_q[0]) : cpol;
    assign mosi    = busy && txw_q[bit_pos(drv_bit, wide, lsb)];
    assign ss_n    = !busy;
    assign rx_word = rxw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            edge_q <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy   <= 1'b1;
                edge_q <= '0;
                txw_q  <= word;
                rxw_q  <= '0;
            end else if (busy && tick) begin
                if (is_sample) rxw_q[bit_pos(smp_bit, wide, lsb)] <= miso;
                edge_q <= edge_q + EDGE_W'(1);
                if ((edge_q + EDGE_W'(1)) == edges_for(wide)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_bufmaster.sv
module spi_bufmaster
    import spi_bm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                tx_we,
    input  logic [DATA_W-1:0]   tx_wdata,
    input  logic                rx_re,
    output logic [DATA_W-1:0]   rx_rdata,
    input  logic                clr_we,
    input  logic [STICKY_W-1:0] clr_mask,
    output logic [STAT_W-1:0]   status,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic                ss_n,
    input  logic                ss_in_n
);
    ctl_t              ctl_q;
    logic [DATA_W-1:0] tx_buf_q, last_q, rx_buf_q;
    logic              tx_full_q, rx_full_q;
    logic              done_q, under_q, over_q, fault_q;

    logic              eng_busy, eng_done, eng_tick, ssin_s;
    logic [DATA_W-1:0] eng_rx, load_word;
    logic              abort, start, fault_hit, rx_full_eff;
    logic [STICKY_W-1:0] clr;
    stat_t             stat;

    spi_bm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ssin_sync (
        .clk(clk), .rst(rst), .async_in(ss_in_n), .sync_out(ssin_s)
    );

    spi_bm_halftick u_half (
        .clk(clk), .rst(rst), .run(eng_busy), .div(ctl_q.div), .tick(eng_tick)
    );

    spi_bm_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(eng_tick),
        .word(load_word), .wide(ctl_q.wide), .lsb(ctl_q.lsb_first),
        .cpol(ctl_q.cpol), .cpha(ctl_q.cpha), .miso(miso),
        .busy(eng_busy), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .done(eng_done), .rx_word(eng_rx)
    );

    always_comb begin
        abort       = !ctl_q.enable || fault_q;
        start       = !abort && !eng_busy && (tx_full_q || rx_re);
        load_word   = tx_full_q ? tx_buf_q : (ctl_q.send_last ? last_q : '0);
        rx_full_eff = rx_full_q && !rx_re;
        fault_hit   = ctl_q.ssin_en && ctl_q.enable && !ssin_s;
        clr         = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            tx_buf_q  <= '0;
            last_q    <= '0;
            rx_buf_q  <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            done_q    <= 1'b0;
            under_q   <= 1'b0;
            over_q    <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);

            if (start && tx_full_q) begin
                last_q    <= tx_buf_q;
                tx_full_q <= 1'b0;
            end
            if (tx_we) begin
                tx_buf_q  <= tx_wdata;
                tx_full_q <= 1'b1;
            end

            if (eng_done) begin
                if (!rx_full_eff || ctl_q.get_more) begin
                    rx_buf_q  <= eng_rx;
                    rx_full_q <= 1'b1;
                end
            end else if (rx_re) begin
                rx_full_q <= 1'b0;
            end

            done_q  <= (done_q  && !clr[0]) || eng_done;
            under_q <= (under_q && !clr[1]) || (start && !tx_full_q);
            over_q  <= (over_q  && !clr[2]) || (eng_done && rx_full_eff);
            fault_q <= (fault_q && !clr[3]) || fault_hit;
        end
    end

    always_comb begin
        stat.busy     = eng_busy;
        stat.rx_full  = rx_full_q;
        stat.tx_full  = tx_full_q;
        stat.fault    = fault_q;
        stat.rx_over  = over_q;
        stat.tx_under = under_q;
        stat.done     = done_q;
    end

    assign status   = stat;
    assign rx_rdata = rx_buf_q;
endmodule

// File: rtl/spi_bufmaster_chk.sv
module spi_bufmaster_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ctl_bits,
    input logic        sclk,
    input logic        ss_n,
    input logic [6:0]  status,
    input logic        rx_re,
    input logic        clr_we,
    input logic [3:0]  clr_mask,
    input logic [15:0] rx_rdata
);
    // R4: with select released the clock rests at the polarity level
    p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> (sclk == ctl_bits[3]));

    // R13: a disabled engine releases select on the next cycle
    p_disable_stops_r13: assert property (@(posedge clk) disable iff (rst)
        !ctl_bits[0] |=> ss_n);

    // R12: a pending mode fault keeps the bus released
    p_fault_halts_r12: assert property (@(posedge clk) disable iff (rst)
        status[3] |=> ss_n);

    // R8: underflow flag stays until cleared
    p_under_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !(clr_we && clr_mask[1])) |=> status[1]);

    // R9: overflow flag stays until cleared
    p_over_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !(clr_we && clr_mask[2])) |=> status[2]);

    // R9: with discard policy a held unread word never changes
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !rx_re && !ctl_bits[6]) |=> $stable(rx_rdata));

    // R10: completion flag stays until cleared
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !(clr_we && clr_mask[0])) |=> status[0]);
endmodule

bind spi_bufmaster spi_bufmaster_chk u_chk (
    .clk(clk), .rst(rst), .ctl_bits(ctl_q), .sclk(sclk), .ss_n(ss_n),
    .status(status), .rx_re(rx_re), .clr_we(clr_we), .clr_mask(clr_mask),
    .rx_rdata(rx_rdata)
);

// File: tb/spi_bufmaster_tb_top.sv
`timescale 1ns/1ps
module spi_bufmaster_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        tx_we = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_re = 1'b0;
    logic [15:0] rx_rdata;
    logic        clr_we = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic [6:0]  status;
    logic        sclk, mosi, ss_n;
    logic        miso = 1'b0;
    logic        ss_in_n = 1'b1;

    always #2.5 clk = ~clk;

    spi_bufmaster dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .clr_we(clr_we), .clr_mask(clr_mask), .status(status),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .ss_in_n(ss_in_n)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    int low_cnt = 0;

    // reference model state
    logic [15:0] m_ctl, m_txb, m_last, m_rxb, m_word, m_acc, m_cap;
    logic [15:0] slave_word = 16'h0000;
    bit m_txf, m_rxf, m_busy, m_pend, m_done, m_under, m_over, m_fault, m_s1, m_s2;
    int m_t, m_cnt;

    function automatic int posn(int b, bit wide, bit lsb);
        return lsb ? b : ((wide ? 15 : 7) - b);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        bit en, wide, lsb, cpha, sl, gm, sen, ab, tk, st, fe;
        int div, nedge;
        logic [3:0] c;
        if (rst) begin
            m_ctl = 0; m_txb = 0; m_last = 0; m_rxb = 0; m_word = 0; m_acc = 0; m_cap = 0;
            m_txf = 0; m_rxf = 0; m_busy = 0; m_pend = 0; m_done = 0; m_under = 0;
            m_over = 0; m_fault = 0; m_s1 = 1; m_s2 = 1; m_t = 0; m_cnt = 0;
        end else begin
            en = m_ctl[0]; wide = m_ctl[1]; lsb = m_ctl[2]; cpha = m_ctl[4];
            sl = m_ctl[5]; gm = m_ctl[6]; sen = m_ctl[7]; div = int'(m_ctl[15:8]);
            nedge = wide ? 32 : 16;
            ab = !en || m_fault;
            tk = m_busy && (m_cnt == div);
            st = !ab && !m_busy && (m_txf || rx_re);
            c = clr_we ? clr_mask : 4'h0;
            if (c[0]) m_done = 0;
            if (c[1]) m_under = 0;
            if (c[2]) m_over = 0;
            if (c[3]) m_fault = 0;
            if (m_pend) begin
                fe = m_rxf && !rx_re;
                if (fe) m_over = 1;
                if (!fe || gm) begin m_rxb = m_acc; m_rxf = 1; end
                m_done = 1;
            end else if (rx_re) m_rxf = 0;
            if (sen && en && !m_s2) m_fault = 1;
            m_s2 = m_s1; m_s1 = ss_in_n;
            if (!m_busy || tk) m_cnt = 0; else m_cnt++;
            m_pend = 0;
            if (ab) m_busy = 0;
            else if (st) begin
                if (m_txf) begin m_word = m_txb; m_last = m_txb; m_txf = 0; end
                else begin m_under = 1; m_word = sl ? m_last : 16'h0; end
                m_busy = 1; m_t = 0; m_acc = 0; m_cap = 0;
            end else if (tk) begin
                if ((m_t % 2) == int'(cpha)) begin
                    m_acc[posn(m_t / 2, wide, lsb)] = miso;
                    m_cap[posn(m_t / 2, wide, lsb)] = mosi;
                end
                m_t++;
                if (m_t == nedge) begin m_busy = 0; m_pend = 1; end
            end
            if (tx_we) begin m_txb = tx_wdata; m_txf = 1; end
            if (ctl_we) m_ctl = ctl_wdata;
        end
    end

    // per-cycle comparison, slave drive and watchdog
    always @(negedge clk) begin : compare
        int drv;
        int exp_mosi;
        cycles++;
        if (!rst) begin
            drv = (m_ctl[4] && m_t != 0) ? (m_t - 1) / 2 : m_t / 2;
            exp_mosi = m_busy ? int'(m_word[posn(drv, m_ctl[1], m_ctl[2])]) : 0;
            chk("R5", "sclk", int'(sclk), m_busy ? int'(m_ctl[3] ^ m_t[0]) : int'(m_ctl[3]));
            chk("R3", "mosi", int'(mosi), exp_mosi);
            chk("R7", "ss_n", int'(ss_n), int'(!m_busy));
            chk("R10", "status", int'(status),
                int'({m_busy, m_rxf, m_txf, m_fault, m_over, m_under, m_done}));
            chk("R9", "rx_rdata", int'(rx_rdata), int'(m_rxb));
            if (!ss_n) low_cnt++;
        end
        miso = m_busy ? slave_word[posn(m_t / 2, m_ctl[1], m_ctl[2])] : 1'b0;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(logic [15:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic push_tx(logic [15:0] d);
        @(negedge clk); tx_we = 1'b1; tx_wdata = d;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_re = 1'b1;
        @(negedge clk); rx_re = 1'b0;
    endtask

    task automatic clear(logic [3:0] m);
        @(negedge clk); clr_we = 1'b1; clr_mask = m;
        @(negedge clk); clr_we = 1'b0; clr_mask = 4'h0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!m_busy && !m_pend && !m_txf) break;
        end
    endtask

    task automatic cleanup();
        write_ctl(16'h0100);
        pop_rx();
        clear(4'hF);
    endtask

    initial begin
        cyc(4);
        chk("R1", "reset ss_n", int'(ss_n), 1);
        chk("R1", "reset sclk", int'(sclk), 0);
        chk("R1", "reset mosi", int'(mosi), 0);
        chk("R1", "reset status", int'(status), 0);
        rst = 1'b0;
        cyc(2);

        // 16-bit, MSB first, polarity 0, phase 0, divider 1
        write_ctl(16'h0103);
        slave_word = 16'h3C5A;
        push_tx(16'hA5C3);
        wait_quiet();
        chk("R2", "16-bit rx word", int'(rx_rdata), 16'h3C5A);
        chk("R3", "msb-first mosi word", int'(m_cap), 16'hA5C3);
        chk("R10", "done and rx full", int'(status[5] && status[0]), 1);
        cleanup();

        // 8-bit, LSB first, polarity 1, phase 1, divider 2
        write_ctl(16'h021D);
        slave_word = 16'hFFB7;
        low_cnt = 0;
        push_tx(16'h0096);
        wait_quiet();
        chk("R2", "8-bit rx word", int'(rx_rdata), 16'h00B7);
        chk("R3", "lsb-first mosi word", int'(m_cap), 16'h0096);
        chk("R5", "phase 1 rx word", int'(rx_rdata), 16'h00B7);
        chk("R6", "select low cycles", low_cnt, 48);
        chk("R4", "idle sclk high", int'(sclk), 1);
        cleanup();

        // queued second word
        write_ctl(16'h0103);
        slave_word = 16'h1357;
        push_tx(16'h1234);
        push_tx(16'h5678);
        @(negedge clk);
        chk("R7", "queued while busy", int'(status[6] && status[4]), 1);
        wait_quiet();
        chk("R7", "queue drained", int'(status[4]), 0);
        chk("R7", "second word sent", int'(m_cap), 16'h5678);
        cleanup();

        // underflow, zero fill
        write_ctl(16'h0103);
        pop_rx();
        wait_quiet();
        chk("R8", "zero fill word", int'(m_cap), 0);
        chk("R8", "underflow flag", int'(status[1]), 1);
        cleanup();

        // underflow, resend last
        write_ctl(16'h0123);
        pop_rx();
        wait_quiet();
        chk("R8", "resent word", int'(m_cap), 16'h5678);
        chk("R8", "underflow flag resend", int'(status[1]), 1);
        cleanup();

        // overflow, discard
        write_ctl(16'h0103);
        slave_word = 16'h1111;
        push_tx(16'h0F0F);
        wait_quiet();
        slave_word = 16'h2222;
        push_tx(16'hF0F0);
        wait_quiet();
        chk("R9", "discard keeps old", int'(rx_rdata), 16'h1111);
        chk("R9", "overflow flag", int'(status[2]), 1);

        // W1C partial clear
        clear(4'b0001);
        chk("R11", "done cleared", int'(status[0]), 0);
        chk("R11", "overflow kept", int'(status[2]), 1);
        clear(4'b0100);
        chk("R11", "overflow cleared", int'(status[2]), 0);

        // overflow, replace
        write_ctl(16'h0143);
        slave_word = 16'h3333;
        push_tx(16'h00FF);
        wait_quiet();
        chk("R9", "replace takes new", int'(rx_rdata), 16'h3333);
        chk("R9", "overflow flag again", int'(status[2]), 1);
        cleanup();

        // mode fault
        write_ctl(16'h0183);
        slave_word = 16'h4444;
        push_tx(16'hAAAA);
        cyc(6);
        ss_in_n = 1'b0;
        cyc(4);
        chk("R12", "fault flag", int'(status[3]), 1);
        chk("R12", "select released", int'(ss_n), 1);
        push_tx(16'h5555);
        ss_in_n = 1'b1;
        cyc(5);
        chk("R12", "held while fault", int'(status[6]), 0);
        chk("R12", "word still queued", int'(status[4]), 1);
        clear(4'b1000);
        wait_quiet();
        chk("R12", "resumed after clear", int'(m_cap), 16'h5555);
        cleanup();

        // disable mid-transfer
        write_ctl(16'h010B);
        push_tx(16'hC3C3);
        cyc(10);
        write_ctl(16'h010A);
        cyc(2);
        chk("R13", "select released", int'(ss_n), 1);
        chk("R13", "sclk idle", int'(sclk), 1);

        cyc(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule